// File: doc/BRIEF.md
# Tagged Instruction Sampling Unit

This block profiles a pipelined processor by following single instructions rather than counting events. A programmable sampling counter advances by the number of valid instructions in each fetch group. When that counter carries out of its top bit, the block marks one instruction of the current group, with the slot picked by a free-running LFSR. It also hands the pipeline a small sample identifier that travels with the marked instruction. Pipeline stages further down report trap, completion, retire and abort events together with the identifier of the instruction they concern. The block keeps only the events whose identifier matches the live sample.

The block captures the marked instruction's PC, its instruction cache miss flag and its predicted direction at fetch. Later it records whether the instruction trapped and the trap code, whether it retired or was flushed, and the number of cycles between its completion report and its retirement. When the instruction leaves the pipeline, the block raises an interrupt and freezes its profile registers. Handler software reads them through a small address/data read port and then writes the acknowledge. The acknowledge clears the interrupt and reloads the counter from a programmable start value. Only one instruction is ever under observation, so the attribution has no skew or smear.

Top module: `inst_sampler`

## Requirements
- R1: While no sample is live and no acknowledge is present, each cycle with `fetchValid` high adds `fetchCount` to the CNT_W-bit sampling counter. A tag is issued only in a cycle where that addition carries out of bit CNT_W-1. Cycles with `fetchValid` low neither count nor tag.
- R2: In a tagging cycle, `tagMark` has exactly one bit set, combinationally, at a slot index below `fetchCount`. The index comes from an LFSR that advances every cycle, so successive samples do not always land on the same slot.
- R3: Read address 0 returns the tagged PC, which is `fetchPc + 4*slot`.
- R4: Read address 1 returns the fetch record: bit 0 is the group's I-cache miss flag and bit 1 is `fetchPredTaken[slot]`. Read addresses 5 to 7 return zero.
- R5: A trap report with the live identifier sets bit 1 of read address 2 and stores `trapCode` in bits 5:2 of the same register.
- R6: A retire report with the live identifier sets bit 0 of address 2 and ends the sample. An abort report with the live identifier ends the sample with bit 0 cleared. In either case `irq` is high after that clock edge. If both arrive in the same cycle, the retire wins.
- R7: `tagId` presents the previous sample identifier plus one (mod 2^ID_W), and a tag adopts it. Reports carrying any other identifier change nothing.
- R8: Read address 3 returns the number of cycles from the completion report to the retire report (0 if they share a cycle or no completion came). It saturates at 2^DLY_W-1. An abort does not change it.
- R9: From a tag until the acknowledge, no further tag is issued and the counter holds its value. Address 4 reports bit 0 = interrupt pending, bit 1 = sample in flight, bits 3:2 = live identifier.
- R10: An acknowledge while idle or while the interrupt is pending clears `irq` on the next edge and loads the counter from `startVal`. An acknowledge while a sample is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startVal | input | CNT_W | Counter value loaded on acknowledge |
| fetchValid | input | 1 | Fetch group present this cycle |
| fetchCount | input | $clog2(SLOTS+1) | Valid instructions in the group |
| fetchPc | input | PC_W | PC of slot 0 (slots are 4 bytes apart) |
| fetchIcMiss | input | 1 | Group missed in the instruction cache |
| fetchPredTaken | input | SLOTS | Predicted-taken flag per slot |
| tagMark | output | SLOTS | One-hot mark of the sampled slot |
| tagId | output | ID_W | Identifier to attach to a marked instruction |
| trapValid | input | 1 | Trap report |
| trapId | input | ID_W | Identifier of the trapping instruction |
| trapCode | input | TRAP_W | Encoded trap kind |
| doneValid | input | 1 | Completion report (ready to retire) |
| doneId | input | ID_W | Identifier of the completed instruction |
| retireValid | input | 1 | Retire report |
| retireId | input | ID_W | Identifier of the retired instruction |
| abortValid | input | 1 | Flush report |
| abortId | input | ID_W | Identifier of the flushed instruction |
| rdAddr | input | 3 | Profile register address |
| rdData | output | PC_W | Profile register contents |
| ackWrite | input | 1 | Software acknowledge |
| irq | output | 1 | Sample ready for software |

## Verification
The bench puts the counter a few instructions short of carry, so an off-by-one overflow test tags one group early or late. It also mixes in an idle fetch that a careless counter would add. It sends reports with a stale identifier and an acknowledge in mid-flight, which a design without identifier matching or state gating would take as an early finish or a lost sample. The delay is checked at an exact count and again past its ceiling, where a wrapping counter returns a small value. Aborts must leave the retired bit clear. A design that kept counting while the interrupt waits would tag a second instruction and overwrite unread data.

// File: rtl/isu_pkg.sv
package isu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_DONE  = 2'd2
  } sampleStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic counting;
    logic reload;
    logic tagNow;
    logic recTrap;
    logic startDly;
    logic finishRet;
    logic finishAbt;
  } strobeT;

  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

  localparam logic [2:0] ADDR_PC      = 3'd0;
  localparam logic [2:0] ADDR_FETCH   = 3'd1;
  localparam logic [2:0] ADDR_OUTCOME = 3'd2;
  localparam logic [2:0] ADDR_DELAY   = 3'd3;
  localparam logic [2:0] ADDR_STATUS  = 3'd4;

endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   fetchValid,
  input  logic   groupNonEmpty,
  input  logic   overflow,
  input  logic   ackWrite,
  input  logic   trapHit,
  input  logic   doneHit,
  input  logic   retireHit,
  input  logic   abortHit,
  output strobeT strobe,
  output logic   irq,
  output logic   tracking
);

  sampleStateT state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        strobe.counting = !ackWrite;
        strobe.reload   = ackWrite;
        if (!ackWrite && fetchValid && groupNonEmpty && overflow) begin
          strobe.tagNow = 1'b1;
          stateNxt      = ST_TRACK;
        end
      end
      ST_TRACK: begin
        strobe.recTrap  = trapHit;
        strobe.startDly = doneHit;
        if (retireHit) begin
          strobe.finishRet = 1'b1;
          stateNxt         = ST_DONE;
        end else if (abortHit) begin
          strobe.finishAbt = 1'b1;
          stateNxt         = ST_DONE;
        end
      end
      ST_DONE: begin
        if (ackWrite) begin
          strobe.reload = 1'b1;
          stateNxt      = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign irq      = (state == ST_DONE);
  assign tracking = (state == ST_TRACK);

endmodule

// File: rtl/isu_dpath.sv
module isu_dpath
  import isu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CNT_W  = 16,
  parameter int SLOTS  = 4,
  parameter int ID_W   = 2,
  parameter int TRAP_W = 4,
  parameter int DLY_W  = 8,
  localparam int CW     = $clog2(SLOTS + 1),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              irq,
  input  logic              tracking,
  input  logic [CNT_W-1:0]  startVal,
  input  logic              fetchValid,
  input  logic [CW-1:0]     fetchCount,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic              fetchIcMiss,
  input  logic [SLOTS-1:0]  fetchPredTaken,
  input  logic              trapValid,
  input  logic [ID_W-1:0]   trapId,
  input  logic [TRAP_W-1:0] trapCode,
  input  logic              doneValid,
  input  logic [ID_W-1:0]   doneId,
  input  logic              retireValid,
  input  logic [ID_W-1:0]   retireId,
  input  logic              abortValid,
  input  logic [ID_W-1:0]   abortId,
  input  logic [2:0]        rdAddr,
  output logic [PC_W-1:0]   rdData,
  output logic              overflow,
  output logic              trapHit,
  output logic              doneHit,
  output logic              retireHit,
  output logic              abortHit,
  output logic [SLOTS-1:0]  tagMark,
  output logic [ID_W-1:0]   tagId
);

  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W:0]    cntSum;
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] divisor;
  logic [LFSR_W-1:0] modVal;
  logic [SLOT_W-1:0] slotIdx;
  logic [ID_W-1:0]   idReg;
  logic [PC_W-1:0]   pcReg;
  logic              icMissReg;
  logic              predReg;
  logic              retiredReg;
  logic              trappedReg;
  logic [TRAP_W-1:0] trapCodeReg;
  logic [DLY_W-1:0]  dlyCnt;
  logic [DLY_W-1:0]  dlyInc;
  logic              dlyRun;

  // sampling counter
  assign cntSum   = {1'b0, sampleCnt} + (CNT_W+1)'(fetchCount);
  assign overflow = cntSum[CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sampleCnt <= '0;
    else if (strobe.reload)                 sampleCnt <= startVal;
    else if (strobe.counting && fetchValid) sampleCnt <= cntSum[CNT_W-1:0];
  end

  // slot selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lfsr <= LFSR_SEED;
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ LFSR_TAPS;
    else              lfsr <= lfsr >> 1;
  end

  assign divisor = (fetchCount == '0) ? LFSR_W'(1) : LFSR_W'(fetchCount);
  assign modVal  = lfsr % divisor;
  assign slotIdx = SLOT_W'(modVal);

  for (genvar s = 0; s < SLOTS; s++) begin : g_mark
    assign tagMark[s] = strobe.tagNow && (slotIdx == SLOT_W'(s));
  end

  // identifier matching
  assign tagId     = idReg + 1'b1;
  assign trapHit   = trapValid   && (trapId   == idReg);
  assign doneHit   = doneValid   && (doneId   == idReg);
  assign retireHit = retireValid && (retireId == idReg);
  assign abortHit  = abortValid  && (abortId  == idReg);

  assign dlyInc = (dlyCnt == DLY_MAX) ? dlyCnt : dlyCnt + 1'b1;

  // profile registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg       <= '0;
      pcReg       <= '0;
      icMissReg   <= 1'b0;
      predReg     <= 1'b0;
      retiredReg  <= 1'b0;
      trappedReg  <= 1'b0;
      trapCodeReg <= '0;
      dlyCnt      <= '0;
      dlyRun      <= 1'b0;
    end else if (strobe.tagNow) begin
      idReg       <= tagId;
      pcReg       <= fetchPc + (PC_W'(slotIdx) << 2);
      icMissReg   <= fetchIcMiss;
      predReg     <= fetchPredTaken[slotIdx];
      retiredReg  <= 1'b0;
      trappedReg  <= 1'b0;
      trapCodeReg <= '0;
      dlyCnt      <= '0;
      dlyRun      <= 1'b0;
    end else begin
      if (strobe.recTrap) begin
        trappedReg  <= 1'b1;
        trapCodeReg <= trapCode;
      end
      if (strobe.finishRet) begin
        retiredReg <= 1'b1;
        dlyRun     <= 1'b0;
        if (strobe.startDly) dlyCnt <= '0;
        else if (dlyRun)     dlyCnt <= dlyInc;
      end else if (strobe.finishAbt) begin
        retiredReg <= 1'b0;
        dlyRun     <= 1'b0;
      end else if (strobe.startDly) begin
        dlyCnt <= '0;
        dlyRun <= 1'b1;
      end else if (dlyRun) begin
        dlyCnt <= dlyInc;
      end
    end
  end

  // read port
  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_PC: rdData = pcReg;
      ADDR_FETCH: begin
        rdData[0] = icMissReg;
        rdData[1] = predReg;
      end
      ADDR_OUTCOME: begin
        rdData[0]            = retiredReg;
        rdData[1]            = trappedReg;
        rdData[2+:TRAP_W]    = trapCodeReg;
      end
      ADDR_DELAY: rdData[DLY_W-1:0] = dlyCnt;
      ADDR_STATUS: begin
        rdData[0]         = irq;
        rdData[1]         = tracking;
        rdData[2+:ID_W]   = idReg;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/inst_sampler.sv
module inst_sampler
  import isu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CNT_W  = 16,
  parameter int SLOTS  = 4,
  parameter int ID_W   = 2,
  parameter int TRAP_W = 4,
  parameter int DLY_W  = 8,
  localparam int CW     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  startVal,
  input  logic              fetchValid,
  input  logic [CW-1:0]     fetchCount,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic              fetchIcMiss,
  input  logic [SLOTS-1:0]  fetchPredTaken,
  output logic [SLOTS-1:0]  tagMark,
  output logic [ID_W-1:0]   tagId,
  input  logic              trapValid,
  input  logic [ID_W-1:0]   trapId,
  input  logic [TRAP_W-1:0] trapCode,
  input  logic              doneValid,
  input  logic [ID_W-1:0]   doneId,
  input  logic              retireValid,
  input  logic [ID_W-1:0]   retireId,
  input  logic              abortValid,
  input  logic [ID_W-1:0]   abortId,
  input  logic [2:0]        rdAddr,
  output logic [PC_W-1:0]   rdData,
  input  logic              ackWrite,
  output logic              irq
);

  strobeT strobe;
  logic   overflow, tracking;
  logic   trapHit, doneHit, retireHit, abortHit;

  isu_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .fetchValid    (fetchValid),
    .groupNonEmpty (fetchCount != '0),
    .overflow      (overflow),
    .ackWrite      (ackWrite),
    .trapHit       (trapHit),
    .doneHit       (doneHit),
    .retireHit     (retireHit),
    .abortHit      (abortHit),
    .strobe        (strobe),
    .irq           (irq),
    .tracking      (tracking)
  );

  isu_dpath #(
    .PC_W(PC_W), .CNT_W(CNT_W), .SLOTS(SLOTS),
    .ID_W(ID_W), .TRAP_W(TRAP_W), .DLY_W(DLY_W)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .irq            (irq),
    .tracking       (tracking),
    .startVal       (startVal),
    .fetchValid     (fetchValid),
    .fetchCount     (fetchCount),
    .fetchPc        (fetchPc),
    .fetchIcMiss    (fetchIcMiss),
    .fetchPredTaken (fetchPredTaken),
    .trapValid      (trapValid),
    .trapId         (trapId),
    .trapCode       (trapCode),
    .doneValid      (doneValid),
    .doneId         (doneId),
    .retireValid    (retireValid),
    .retireId       (retireId),
    .abortValid     (abortValid),
    .abortId        (abortId),
    .rdAddr         (rdAddr),
    .rdData         (rdData),
    .overflow       (overflow),
    .trapHit        (trapHit),
    .doneHit        (doneHit),
    .retireHit      (retireHit),
    .abortHit       (abortHit),
    .tagMark        (tagMark),
    .tagId          (tagId)
  );

endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int SLOTS = 4,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic [CW-1:0]    fetchCount,
  input logic [SLOTS-1:0] tagMark,
  input logic             ackWrite,
  input logic             irq
);

  AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tagMark)); // R2

  AST_TAG_IN_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (tagMark != '0) |-> ({1'b0, tagMark} < ((SLOTS+1)'(1) << fetchCount))); // R2

  AST_TAG_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (tagMark != '0) |-> (fetchValid && !ackWrite)); // R1

  AST_NO_TAG_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (tagMark == '0)); // R9

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (tagMark != '0) |=> (tagMark == '0)); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ackWrite) |=> irq); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irq && ackWrite) |=> !irq); // R10

endmodule

bind inst_sampler isu_checker #(.SLOTS(SLOTS)) u_isu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .fetchValid (fetchValid),
  .fetchCount (fetchCount),
  .tagMark    (tagMark),
  .ackWrite   (ackWrite),
  .irq        (irq)
);

// File: tb/test_inst_sampler.sv
`timescale 1ns/1ps
module test_inst_sampler;

  localparam int PC_W = 32, CNT_W = 16, SLOTS = 4, ID_W = 2, TRAP_W = 4, DLY_W = 8;
  localparam int CW = $clog2(SLOTS + 1);
  localparam int M = 1 << CNT_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CNT_W-1:0] startVal = '0;
  logic fetchValid = 0, fetchIcMiss = 0;
  logic [CW-1:0] fetchCount = '0;
  logic [PC_W-1:0] fetchPc = '0;
  logic [SLOTS-1:0] fetchPredTaken = '0;
  logic [SLOTS-1:0] tagMark;
  logic [ID_W-1:0] tagId;
  logic trapValid = 0, doneValid = 0, retireValid = 0, abortValid = 0, ackWrite = 0;
  logic [ID_W-1:0] trapId = '0, doneId = '0, retireId = '0, abortId = '0;
  logic [TRAP_W-1:0] trapCode = '0;
  logic [2:0] rdAddr = '0;
  logic [PC_W-1:0] rdData;
  logic irq;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  inst_sampler i_inst_sampler (
    .clk(clk), .rstN(rstN), .startVal(startVal),
    .fetchValid(fetchValid), .fetchCount(fetchCount), .fetchPc(fetchPc),
    .fetchIcMiss(fetchIcMiss), .fetchPredTaken(fetchPredTaken),
    .tagMark(tagMark), .tagId(tagId),
    .trapValid(trapValid), .trapId(trapId), .trapCode(trapCode),
    .doneValid(doneValid), .doneId(doneId),
    .retireValid(retireValid), .retireId(retireId),
    .abortValid(abortValid), .abortId(abortId),
    .rdAddr(rdAddr), .rdData(rdData), .ackWrite(ackWrite), .irq(irq)
  );

  task automatic check(string req, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic clearIns();
    fetchValid = 0; fetchCount = '0; fetchIcMiss = 0; fetchPredTaken = '0;
    trapValid = 0; doneValid = 0; retireValid = 0; abortValid = 0; ackWrite = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clearIns();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic readReg(input logic [2:0] a, output logic [PC_W-1:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  function automatic int slotOf(logic [SLOTS-1:0] m);
    for (int s = 0; s < SLOTS; s++) if (m[s]) return s;
    return -1;
  endfunction

  task automatic ack(input int sv);
    startVal = CNT_W'(sv); ackWrite = 1; step();
  endtask

  // one fetch group; returns the observed mark and id
  task automatic fetch(input int cnt, input logic [PC_W-1:0] pc, input logic miss,
                       input logic [SLOTS-1:0] pred,
                       output logic [SLOTS-1:0] mark, output logic [ID_W-1:0] id);
    fetchValid = 1; fetchCount = CW'(cnt); fetchPc = pc; fetchIcMiss = miss;
    fetchPredTaken = pred; #1;
    mark = tagMark; id = tagId;
    step();
  endtask

  task automatic testReset();
    logic [PC_W-1:0] v;
    check("R9 reset irq", irq, 0);
    check("R2 reset tagMark", tagMark, 0);
    readReg(ADDR_STATUS_C, v);
    check("R9 reset status", v, 0);
  endtask

  localparam logic [2:0] ADDR_STATUS_C = 3'd4;

  task automatic testThresholdAndCapture();
    logic [SLOTS-1:0] m; logic [ID_W-1:0] id; logic [PC_W-1:0] v; int s;
    ack(M - 10);
    fetch(4, 32'h1000, 0, 4'h0, m, id);
    check("R1 no tag below carry", m, 0);
    fetch(4, 32'h1010, 0, 4'h0, m, id);
    check("R1 no tag below carry 2", m, 0);
    fetchValid = 0; fetchCount = CW'(4); #1; m = tagMark; step();
    check("R1 invalid fetch ignored", m, 0);
    fetch(4, 32'h2000, 1, 4'b0101, m, id);
    check("R2 one-hot on carry", $countones(m), 1);
    check("R7 first id", id, 1);
    s = slotOf(m);
    readReg(3'd0, v);
    check("R3 tagged pc", v, 32'h2000 + 4 * s);
    readReg(3'd1, v);
    check("R4 fetch record", v, {30'b0, (4'b0101 >> s) & 1'b1, 1'b1});
    readReg(3'd6, v);
    check("R4 unmapped reads zero", v, 0);
    // R9: no second tag while in flight
    fetch(4, 32'h3000, 0, 4'h0, m, id);
    check("R9 no tag in flight", m, 0);
    readReg(3'd4, v);
    check("R9 status tracking", v, (1 << 2) | 2);
    // R7: stale id ignored
    retireValid = 1; retireId = 2'd3; trapValid = 1; trapId = 2'd2; trapCode = 4'h5;
    step();
    check("R7 stale retire ignored", irq, 0);
    readReg(3'd2, v);
    check("R7 stale trap ignored", v, 0);
    // R5 trap
    trapValid = 1; trapId = 2'd1; trapCode = 4'h9; step();
    // R8 delay of 6
    doneValid = 1; doneId = 2'd1; step();
    idle(5);
    check("R6 no irq before retire", irq, 0);
    retireValid = 1; retireId = 2'd1; step();
    check("R6 irq after retire", irq, 1);
    readReg(3'd2, v);
    check("R5 R6 outcome", v, (9 << 2) | 3);
    readReg(3'd3, v);
    check("R8 retire delay", v, 6);
    // R9: counter frozen while pending
    fetch(4, 32'h4000, 0, 4'h0, m, id);
    check("R9 no tag while irq", m, 0);
    check("R10 irq held", irq, 1);
    ack(M - 1);
    check("R10 ack clears irq", irq, 0);
  endtask

  task automatic testAbort();
    logic [SLOTS-1:0] m; logic [ID_W-1:0] id; logic [PC_W-1:0] v;
    fetch(3, 32'h8000, 0, 4'hF, m, id);
    check("R10 reload tags at once", $countones(m), 1);
    check("R2 slot below count", slotOf(m) < 3, 1);
    check("R7 id steps", id, 2);
    abortValid = 1; abortId = id; step();
    check("R6 irq after abort", irq, 1);
    readReg(3'd2, v);
    check("R6 abort not retired", v, 0);
    readReg(3'd3, v);
    check("R8 abort delay zero", v, 0);
    ack(M - 1);
  endtask

  task automatic testAckInFlight();
    logic [SLOTS-1:0] m; logic [ID_W-1:0] id; logic [PC_W-1:0] v;
    fetch(1, 32'hA000, 1, 4'h1, m, id);
    check("R2 single slot", m, 1);
    ack(M - 100);
    check("R10 ack in flight ignored irq", irq, 0);
    readReg(3'd4, v);
    check("R10 still tracking", v[1], 1);
    retireValid = 1; retireId = id; step();
    check("R10 sample survives ack", irq, 1);
    readReg(3'd3, v);
    check("R8 no done gives zero", v, 0);
    readReg(3'd0, v);
    check("R3 pc slot0", v, 32'hA000);
    ack(M - 2);
  endtask

  task automatic testSaturate();
    logic [SLOTS-1:0] m; logic [ID_W-1:0] id; logic [PC_W-1:0] v;
    fetch(2, 32'hB000, 0, 4'h0, m, id);
    check("R1 tag exactly on carry", $countones(m), 1);
    doneValid = 1; doneId = id; step();
    idle(299);
    retireValid = 1; retireId = id; step();
    readReg(3'd3, v);
    check("R8 delay saturates", v, 255);
    ack(M - 1);
  endtask

  task automatic testSpread();
    logic [SLOTS-1:0] m; logic [ID_W-1:0] id; int seen = 0;
    for (int k = 0; k < 6; k++) begin
      idle(k + 1);
      fetch(4, 32'hC000, 0, 4'h0, m, id);
      seen |= m;
      retireValid = 1; retireId = id; step();
      ack(M - 1);
    end
    check("R2 slots vary", $countones(seen) >= 2, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #22 rstN = 1;
    @(posedge clk); #1;
    testReset();
    testThresholdAndCapture();
    testAbort();
    testAckInFlight();
    testSaturate();
    testSpread();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule